// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a 32-bit processor core that runs a small integer instruction subset: word load, word store, five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), branch-if-equal and an absolute jump. A single memory port carries both instruction fetches and data accesses, and one ALU is reused in every step of an instruction. Results pass from one step to the next through internal holding registers: the instruction register, a memory data register, two operand latches and an ALU result latch.

A control state machine takes every instruction through a fetch step and a decode step. Depending on the opcode, an execute step, a memory step and a write-back step follow. Each instruction therefore takes 3, 4 or 5 clock cycles. The fetch step also advances the program counter. The decode step computes a branch target before it is known whether the instruction is a branch. The memory port has no handshake. The attached memory must return read data combinationally in the same cycle the address is presented, and it must accept a write on the rising edge that ends a cycle in which the write strobe is high. Back-pressure is not supported: the core never stalls.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core returns to the fetch step with PC = 0. In the cycle after that edge, `mem_addr` = 0 and `mem_we` = 0.
- R2: Every instruction begins with a fetch cycle that drives `mem_addr` = PC and leaves PC + 4 for the next instruction. A word load (opcode 6'h23) takes 5 cycles, so the next fetch follows 5 cycles after its own fetch.
- R3: An R-format instruction (opcode 0) with funct 6'h20 add, 6'h22 subtract, 6'h24 and, 6'h25 or or 6'h2A set-less-than takes 4 cycles. It writes the result of rs op rt to register rd (bits 15:11).
- R4: A word store (opcode 6'h2B) takes 4 cycles. In its fourth cycle it holds `mem_we` high for exactly one cycle, with `mem_addr` = rs + sign-extended imm[15:0] and `mem_wdata` = rt. `mem_we` is low in every other cycle.
- R5: A word load writes the word read at rs + sign-extended imm into register rt (bits 20:16) in its fifth cycle.
- R6: Branch-if-equal (opcode 6'h04) takes 3 cycles. When rs equals rt, the next fetch address is PC + 4 + (sign-extended imm << 2), and a negative offset works the same way. Otherwise the next fetch address is PC + 4.
- R7: A jump (opcode 6'h02) takes 3 cycles. The next fetch address is {upper 4 bits of PC + 4, imm26, 2'b00}.
- R8: Register 0 always reads as zero, and a write to it has no effect.
- R9: An unknown opcode, or opcode 0 with a funct outside the five listed, returns to fetch after the decode cycle (2 cycles in all). It writes no register and no memory.
- R10: Set-less-than compares the two operands as signed two's-complement values and writes 1 or 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address: PC in fetch, ALU result latch otherwise |
| mem_wdata | output | 32 | Store data (second operand latch) |
| mem_we | output | 1 | Write strobe, high for one cycle per store |
| mem_rdata | input | 32 | Read data, valid in the same cycle as `mem_addr` |

## Verification
The assertions assume that `mem_rdata` settles within the cycle that presents its address. They also assume that `rst` is held high through at least one rising edge before the first instruction. The stimulus meets both conditions: it uses a zero-latency word-indexed memory model and holds reset for three edges. Every memory word that the program reads is preloaded, so no operand latch ever carries an unknown value into a branch comparison or a store. Program addresses stay word-aligned, which matches the assumption that the two low address bits are ignored.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_MEM,
    ST_WB
  } mc_state_e;

  typedef enum logic [1:0] {
    PCS_ALU,
    PCS_OUT,
    PCS_JUMP
  } pc_src_e;

  typedef enum logic {
    AS_PC,
    AS_REG
  } a_sel_e;

  typedef enum logic [1:0] {
    BS_REG,
    BS_FOUR,
    BS_IMM,
    BS_BOFF
  } b_sel_e;

  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b0111;

  localparam logic [5:0] OP_RFMT = 6'h00;
  localparam logic [5:0] OP_J    = 6'h02;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  typedef struct packed {
    logic    ir_we;
    logic    pc_we;
    logic    pc_cond;
    pc_src_e pc_src;
    a_sel_e  a_sel;
    b_sel_e  b_sel;
    logic [3:0] alu_op;
    logic    addr_from_out;
    logic    mem_we;
    logic    mdr_we;
    logic    ab_we;
    logic    out_we;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mdr;
  } mc_ctl_t;

  // {supported, alu code} for an R-format funct value
  function automatic logic [4:0] funct_decode(input logic [5:0] f);
    case (f)
      6'h20:   return {1'b1, ALU_ADD};
      6'h22:   return {1'b1, ALU_SUB};
      6'h24:   return {1'b1, ALU_AND};
      6'h25:   return {1'b1, ALU_OR};
      6'h2A:   return {1'b1, ALU_SLT};
      default: return {1'b0, ALU_ADD};
    endcase
  endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu #(
  parameter int XLEN = 32
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  import mc_pkg::*;

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};  // R10
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [ADDR_W-1:0] ra1,
  input  logic [ADDR_W-1:0] ra2,
  output logic [XLEN-1:0]   rd1,
  output logic [XLEN-1:0]   rd2
);
  localparam int NREGS = 1 << ADDR_W;

  logic [XLEN-1:0] regs [NREGS];

  // entry 0 is never written (R8)
  always_ff @(posedge clk) begin
    for (int i = 1; i < NREGS; i++) begin
      if (we && waddr == ADDR_W'(i)) regs[i] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        opcode,
  input  logic [5:0]        funct,
  output mc_pkg::mc_state_e state,
  output logic              dec_ok,
  output mc_pkg::mc_ctl_t   ctl
);
  import mc_pkg::*;

  mc_state_e  nxt;
  logic [4:0] fdec;

  assign fdec   = funct_decode(funct);
  assign dec_ok = (opcode == OP_LW) || (opcode == OP_SW) || (opcode == OP_BEQ) ||
                  (opcode == OP_J)  || ((opcode == OP_RFMT) && fdec[4]);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = ST_FETCH;
    case (state)
      ST_FETCH: begin
        ctl.ir_we  = 1'b1;
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PCS_ALU;
        ctl.a_sel  = AS_PC;
        ctl.b_sel  = BS_FOUR;
        ctl.alu_op = ALU_ADD;
        nxt        = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.ab_we  = 1'b1;
        ctl.out_we = 1'b1;
        ctl.a_sel  = AS_PC;
        ctl.b_sel  = BS_BOFF;
        ctl.alu_op = ALU_ADD;
        nxt        = dec_ok ? ST_EXEC : ST_FETCH;
      end
      ST_EXEC: begin
        ctl.a_sel = AS_REG;
        case (opcode)
          OP_LW, OP_SW: begin
            ctl.b_sel  = BS_IMM;
            ctl.alu_op = ALU_ADD;
            ctl.out_we = 1'b1;
            nxt        = ST_MEM;
          end
          OP_RFMT: begin
            ctl.b_sel  = BS_REG;
            ctl.alu_op = fdec[3:0];
            ctl.out_we = 1'b1;
            nxt        = ST_MEM;
          end
          OP_BEQ: begin
            ctl.b_sel   = BS_REG;
            ctl.alu_op  = ALU_SUB;
            ctl.pc_cond = 1'b1;
            ctl.pc_src  = PCS_OUT;
          end
          OP_J: begin
            ctl.pc_we  = 1'b1;
            ctl.pc_src = PCS_JUMP;
          end
          default: ;
        endcase
      end
      ST_MEM: begin
        ctl.addr_from_out = 1'b1;
        case (opcode)
          OP_LW: begin
            ctl.mdr_we = 1'b1;
            nxt        = ST_WB;
          end
          OP_SW:   ctl.mem_we = 1'b1;
          OP_RFMT: begin
            ctl.rf_we     = 1'b1;
            ctl.rf_dst_rd = 1'b1;
          end
          default: ;
        endcase
      end
      ST_WB: begin
        ctl.rf_we       = 1'b1;
        ctl.rf_from_mdr = 1'b1;
      end
      default: nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core #(
  parameter int XLEN   = 32,
  parameter int RADR_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic [XLEN-1:0] mem_rdata
);
  import mc_pkg::*;

  localparam int IMM_W = 16;

  mc_state_e state_q;
  mc_ctl_t   ctl;
  logic      dec_ok;

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, out_q;
  logic [XLEN-1:0] rs_val, rt_val;
  logic [XLEN-1:0] alu_a, alu_b, alu_y, pc_next, sext, rf_wdata;
  logic            alu_zero, pc_load;
  logic [RADR_W-1:0] rf_waddr;

  assign sext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_q[31:26]),
    .funct  (ir_q[5:0]),
    .state  (state_q),
    .dec_ok (dec_ok),
    .ctl    (ctl)
  );

  assign rf_waddr = ctl.rf_dst_rd   ? ir_q[15:11] : ir_q[20:16];
  assign rf_wdata = ctl.rf_from_mdr ? mdr_q : out_q;

  mc_regfile #(.XLEN(XLEN), .ADDR_W(RADR_W)) u_rf (
    .clk   (clk),
    .we    (ctl.rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra1   (ir_q[25:21]),
    .ra2   (ir_q[20:16]),
    .rd1   (rs_val),
    .rd2   (rt_val)
  );

  assign alu_a = (ctl.a_sel == AS_PC) ? pc_q : a_q;

  always_comb begin
    case (ctl.b_sel)
      BS_REG:  alu_b = b_q;
      BS_FOUR: alu_b = XLEN'(4);
      BS_IMM:  alu_b = sext;
      default: alu_b = {sext[XLEN-3:0], 2'b00};
    endcase
  end

  mc_alu #(.XLEN(XLEN)) u_alu (
    .op   (ctl.alu_op),
    .a    (alu_a),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  always_comb begin
    case (ctl.pc_src)
      PCS_OUT:  pc_next = out_q;
      PCS_JUMP: pc_next = {pc_q[XLEN-1:28], ir_q[25:0], 2'b00};
      default:  pc_next = alu_y;
    endcase
  end

  assign pc_load = ctl.pc_we | (ctl.pc_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      out_q <= '0;
    end else begin
      if (pc_load)    pc_q  <= pc_next;
      if (ctl.ir_we)  ir_q  <= mem_rdata;
      if (ctl.mdr_we) mdr_q <= mem_rdata;
      if (ctl.ab_we) begin
        a_q <= rs_val;
        b_q <= rt_val;
      end
      if (ctl.out_we) out_q <= alu_y;
    end
  end

  assign mem_addr  = ctl.addr_from_out ? out_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = ctl.mem_we;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst,
  input mc_pkg::mc_state_e state,
  input logic [XLEN-1:0]   pc,
  input logic              mem_we,
  input logic [5:0]        opcode,
  input logic [4:0]        rs_addr,
  input logic [XLEN-1:0]   rs_val,
  input logic              known
);
  import mc_pkg::*;

  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> (state == ST_FETCH && pc == '0));

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (pc == $past(pc) + XLEN'(4)));

  p_store_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == ST_MEM && opcode == OP_SW));

  p_load_wb_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |-> (opcode == OP_LW && $past(state) == ST_MEM));

  p_short_ops_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && (opcode == OP_BEQ || opcode == OP_J)) |=> (state == ST_FETCH));

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && rs_addr == '0) |-> (rs_val == '0));

  p_bad_op_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && !known) |=> (state == ST_FETCH && $stable(pc)));
endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .state   (state_q),
  .pc      (pc_q),
  .mem_we  (mem_we),
  .opcode  (ir_q[31:26]),
  .rs_addr (ir_q[25:21]),
  .rs_val  (rs_val),
  .known   (dec_ok)
);

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  always #10 clk = ~clk;  // 50 MHz

  mc_core u_dut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata)
  );

  logic [31:0] mem [256];
  assign mem_rdata = mem[mem_addr[9:2]];

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] f);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[0]  = enc_i(6'h23, 0, 1, 16'h0100);   // lw r1
    mem[1]  = enc_i(6'h23, 0, 2, 16'h0104);   // lw r2
    mem[2]  = enc_r(1, 2, 3, 6'h20);          // add
    mem[3]  = enc_r(1, 2, 4, 6'h22);          // sub
    mem[4]  = enc_r(1, 2, 5, 6'h24);          // and
    mem[5]  = enc_r(1, 2, 6, 6'h25);          // or
    mem[6]  = enc_r(2, 1, 7, 6'h2A);          // slt 3<5
    mem[7]  = enc_i(6'h2B, 0, 3, 16'h0200);
    mem[8]  = enc_i(6'h2B, 0, 4, 16'h0204);
    mem[9]  = enc_i(6'h2B, 0, 5, 16'h0208);
    mem[10] = enc_i(6'h2B, 0, 6, 16'h020C);
    mem[11] = enc_i(6'h2B, 0, 7, 16'h0210);
    mem[12] = enc_r(1, 2, 0, 6'h20);          // write to r0
    mem[13] = enc_i(6'h2B, 0, 0, 16'h0214);
    mem[14] = 32'hFC00_0000;                  // unknown opcode
    mem[15] = enc_i(6'h04, 1, 2, 16'd5);      // beq not taken
    mem[16] = enc_i(6'h04, 1, 1, 16'd2);      // beq taken -> 76
    mem[17] = enc_i(6'h2B, 0, 1, 16'h0218);   // skipped
    mem[18] = enc_i(6'h2B, 0, 1, 16'h0218);   // skipped
    mem[19] = {6'h02, 26'd24};                // j 96
    mem[20] = enc_i(6'h2B, 0, 1, 16'h0218);   // skipped
    mem[24] = enc_i(6'h2B, 0, 1, 16'h021C);
    mem[25] = enc_i(6'h23, 0, 8, 16'h0108);   // lw r8 = -1
    mem[26] = enc_r(8, 1, 9, 6'h2A);          // slt -1<5
    mem[27] = enc_i(6'h2B, 0, 9, 16'h0220);
    mem[28] = enc_i(6'h04, 0, 0, 16'hFFFF);   // beq to self
    mem[64] = 32'd5;
    mem[65] = 32'd3;
    mem[66] = 32'hFFFF_FFFF;
    forever begin
      @(posedge clk);
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
  end

  typedef struct packed {
    logic        is_wr;
    logic [31:0] cyc;
    logic [31:0] addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'd0,  32'h000, 32'h0, 8'd2},   // R2 first fetch
    '{1'b0, 32'd5,  32'h004, 32'h0, 8'd2},   // R2 lw is 5 cycles
    '{1'b0, 32'd10, 32'h008, 32'h0, 8'd5},   // R5 second lw length
    '{1'b0, 32'd14, 32'h00C, 32'h0, 8'd3},   // R3 R-format 4 cycles
    '{1'b1, 32'd33, 32'h200, 32'd8, 8'd3},   // R3 add via store
    '{1'b1, 32'd37, 32'h204, 32'd2, 8'd3},   // R3 sub
    '{1'b1, 32'd41, 32'h208, 32'd1, 8'd3},   // R3 and
    '{1'b1, 32'd45, 32'h20C, 32'd7, 8'd4},   // R4 store of or result
    '{1'b1, 32'd49, 32'h210, 32'd1, 8'd10},  // R10 slt 3<5
    '{1'b1, 32'd57, 32'h214, 32'd0, 8'd8},   // R8 r0 still zero
    '{1'b0, 32'd58, 32'h038, 32'h0, 8'd4},   // R4 store is 4 cycles
    '{1'b0, 32'd60, 32'h03C, 32'h0, 8'd9},   // R9 unknown op 2 cycles
    '{1'b0, 32'd63, 32'h040, 32'h0, 8'd6},   // R6 beq not taken
    '{1'b0, 32'd66, 32'h04C, 32'h0, 8'd6},   // R6 beq taken
    '{1'b0, 32'd69, 32'h060, 32'h0, 8'd7},   // R7 jump
    '{1'b1, 32'd72, 32'h21C, 32'd5, 8'd7},   // R7 no stray store skipped
    '{1'b0, 32'd73, 32'h064, 32'h0, 8'd4},   // R4
    '{1'b0, 32'd78, 32'h068, 32'h0, 8'd5},   // R5
    '{1'b1, 32'd85, 32'h220, 32'd1, 8'd10},  // R10 signed -1<5
    '{1'b0, 32'd86, 32'h070, 32'h0, 8'd2},   // R2
    '{1'b0, 32'd89, 32'h070, 32'h0, 8'd6},   // R6 negative offset
    '{1'b0, 32'd92, 32'h070, 32'h0, 8'd6}    // R6
  };

  int  checks = 0;
  int  errors = 0;
  int  cyc    = 0;
  bit  done   = 1'b0;

  task automatic chk(bit ok, int req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
  endtask

  initial begin
    bit stray;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_addr == 32'h0, 1, "reset addr", mem_addr, 32'h0);   // R1
    chk(mem_we == 1'b0, 1, "reset we", {31'd0, mem_we}, 32'h0);  // R1
    rst = 1'b0;
    cyc = 0;

    for (int i = 0; i < NV; i++) begin
      stray = 1'b0;
      while (cyc < int'(VEC[i].cyc)) begin
        step();
        if (cyc < int'(VEC[i].cyc) && mem_we) stray = 1'b1;
      end
      chk(!stray, int'(VEC[i].req), "unexpected store", {31'd0, stray}, 32'h0);
      chk(mem_we == VEC[i].is_wr, int'(VEC[i].req), "we", {31'd0, mem_we}, {31'd0, VEC[i].is_wr});
      chk(mem_addr == VEC[i].addr, int'(VEC[i].req), "addr", mem_addr, VEC[i].addr);
      if (VEC[i].is_wr)
        chk(mem_wdata == VEC[i].data, int'(VEC[i].req), "wdata", mem_wdata, VEC[i].data);
    end

    // R1: reset taken in the middle of a load
    release_reset();
    rst = 1'b1;
    release_reset();
    step();
    step();
    rst = 1'b1;
    @(negedge clk);
    chk(mem_addr == 32'h0, 1, "mid-run reset addr", mem_addr, 32'h0);
    chk(mem_we == 1'b0, 1, "mid-run reset we", {31'd0, mem_we}, 32'h0);
    rst = 1'b0;
    cyc = 0;
    repeat (5) step();
    chk(mem_addr == 32'h4, 2, "restart second fetch", mem_addr, 32'h4);  // R2

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=%h expected=%h", cyc, 32'd92);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule